// File: doc/BRIEF.md
# Unknown-Aware Bitwise Logic Unit

This combinational unit evaluates logic operators on operands that may contain unknown bits, using only two-valued signals. Each operand arrives as a data vector plus a mask vector; a set mask bit marks that position as unknown. The result comes back in the same split form. Internally every bit is expanded into three mutually exclusive flags (known zero, known one, unknown). The operators combine these flags with controlling-value rules, so a result bit is known wherever the known inputs already decide it, and unknown otherwise.

A 4-bit opcode selects one of thirteen operators. Five act bit by bit. Eight fold whole operands into a single truth value, which is placed in bit 0. The unit is meant for design-checking and emulation datapaths that must carry unknown values through ordinary synthesizable logic.

Top module: `xlogic_unit`

## Requirements
- R1: Wherever an input mask bit is set, the matching input data bit has no effect on either output. Wherever an output mask bit is set, the matching output data bit is 0.
- R2: Opcode 1 (AND) gives a bitwise result: known 0 where either operand bit is known 0, known 1 where both are known 1, unknown otherwise. Opcode 2 (OR) gives known 1 where either bit is known 1, known 0 where both are known 0, unknown otherwise.
- R3: Opcode 3 (XOR) gives an unknown bit wherever either operand bit is unknown, and otherwise the XOR of the two known values. Opcode 4 (XNOR) gives the same bits inverted, with unknowns kept.
- R4: Opcode 0 (NOT of A) inverts each known bit of A and keeps each unknown bit unknown.
- R5: Opcode 5 (reduce-AND of A) gives 0 if any bit is known 0, 1 if all bits are known 1, unknown otherwise. Opcode 6 (reduce-OR of A) gives 1 if any bit is known 1, 0 if all bits are known 0, unknown otherwise.
- R6: Opcode 7 (reduce-XOR of A) is unknown if any bit of A is unknown, and otherwise the parity of A.
- R7: Opcodes 8 (logical AND) and 9 (logical OR) first reduce each operand to a truth value: 1 if any bit is known 1, 0 if all bits are known 0, unknown otherwise. They then apply the AND or OR rule of R2 to the two truth values.
- R8: Opcode 10 (equality) is known 0 if some position has both bits known and different. Otherwise it is unknown if any position of either operand is unknown, and 1 if not. Opcode 11 (inequality) is the inverse, with unknown kept.
- R9: Opcode 12 (case equality) is never unknown. It is 1 exactly when every position matches in state, with unknown counted as a third state that equals only unknown.
- R10: For opcodes 5 to 12, result bits above bit 0 are known 0 (data 0, mask 0).
- R11: Opcodes 13 to 15 return every result bit unknown (mask all ones, data all zeros).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_data | input | WIDTH | Operand A values |
| a_mask | input | WIDTH | Operand A unknown mask |
| b_data | input | WIDTH | Operand B values |
| b_mask | input | WIDTH | Operand B unknown mask |
| opcode | input | 4 | Operator select |
| y_data | output | WIDTH | Result values |
| y_mask | output | WIDTH | Result unknown mask |

## Verification
Two of the unit's functions can decide the same result bit at once: a controlling known value that makes the result known, and a masked data bit that must be ignored. The bench provokes both together. Every vector is applied twice in a row, the second time with random garbage written into the data bits under the mask, and both results must equal the model's result, which is computed from per-bit three-state tables. Operand B is sometimes set equal to A, or equal to A with the masks cleared, so that the equality operators reach their 1 and unknown outcomes as well as 0.

// File: rtl/xlu_pkg.sv
package xlu_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_NOT  = 4'd0,
      OP_AND  = 4'd1,
      OP_OR   = 4'd2,
      OP_XOR  = 4'd3,
      OP_XNOR = 4'd4,
      OP_RAND = 4'd5,
      OP_ROR  = 4'd6,
      OP_RXOR = 4'd7,
      OP_LAND = 4'd8,
      OP_LOR  = 4'd9,
      OP_EQ   = 4'd10,
      OP_NE   = 4'd11,
      OP_CEQ  = 4'd12
   } xop_e;

   typedef struct packed {
      logic zero;
      logic one;
      logic unk;
   } tri_t;

   localparam tri_t T_ZERO = '{zero: 1'b1, one: 1'b0, unk: 1'b0};
   localparam tri_t T_UNK  = '{zero: 1'b0, one: 1'b0, unk: 1'b1};

   function automatic tri_t t_not(tri_t a);
      t_not = '{zero: a.one, one: a.zero, unk: a.unk};
   endfunction

   function automatic tri_t t_and(tri_t a, tri_t b);
      tri_t r;
      r.zero = a.zero | b.zero;
      r.one  = a.one & b.one;
      r.unk  = ~(r.zero | r.one);
      t_and  = r;
   endfunction

   function automatic tri_t t_or(tri_t a, tri_t b);
      t_or = t_not(t_and(t_not(a), t_not(b)));
   endfunction

   function automatic tri_t t_xor(tri_t a, tri_t b);
      tri_t r;
      r.unk  = a.unk | b.unk;
      r.one  = ~r.unk & (a.one ^ b.one);
      r.zero = ~(r.unk | r.one);
      t_xor  = r;
   endfunction
endpackage

// File: rtl/xlu_split.sv
module xlu_split
   import xlu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]       data,
   input  logic [WIDTH-1:0]       mask,
   output tri_t [WIDTH-1:0]       flags
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign flags[i].unk  = mask[i];
      assign flags[i].one  = data[i] & ~mask[i];
      assign flags[i].zero = ~data[i] & ~mask[i];
   end
endmodule

// File: rtl/xlu_lanes.sv
module xlu_lanes
   import xlu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  tri_t [WIDTH-1:0] a,
   input  tri_t [WIDTH-1:0] b,
   output tri_t [WIDTH-1:0] v_not,
   output tri_t [WIDTH-1:0] v_and,
   output tri_t [WIDTH-1:0] v_or,
   output tri_t [WIDTH-1:0] v_xor,
   output tri_t [WIDTH-1:0] v_xnor
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      assign v_not[i]  = t_not(a[i]);
      assign v_and[i]  = t_and(a[i], b[i]);
      assign v_or[i]   = t_or(a[i], b[i]);
      assign v_xor[i]  = t_xor(a[i], b[i]);
      assign v_xnor[i] = t_not(v_xor[i]);

      always_comb begin
         // R2: a known-0 input forces a known-0 AND lane
         if (a[i].zero || b[i].zero)
            p_and_dominant_r2: assert (v_and[i] == T_ZERO)
               else $error("AND lane %0d not forced to zero", i);
         // R3: unknown input makes XOR lane unknown
         if (a[i].unk || b[i].unk)
            p_xor_unknown_r3: assert (v_xor[i] == T_UNK)
               else $error("XOR lane %0d not unknown", i);
      end
   end
endmodule

// File: rtl/xlu_fold.sv
module xlu_fold
   import xlu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  tri_t [WIDTH-1:0] a,
   input  tri_t [WIDTH-1:0] b,
   output tri_t             f_rand,
   output tri_t             f_ror,
   output tri_t             f_rxor,
   output tri_t             f_land,
   output tri_t             f_lor,
   output tri_t             f_eq,
   output tri_t             f_ne,
   output tri_t             f_ceq
);
   logic [WIDTH-1:0] a_z, a_o, a_x, b_z, b_o, b_x;
   logic [WIDTH-1:0] diff_known, any_unk, same_state;

   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         a_z[i] = a[i].zero; a_o[i] = a[i].one; a_x[i] = a[i].unk;
         b_z[i] = b[i].zero; b_o[i] = b[i].one; b_x[i] = b[i].unk;
      end
   end

   assign any_unk    = a_x | b_x;
   assign diff_known = (a_o ^ b_o) & ~any_unk;
   assign same_state = ~(a_z ^ b_z) & ~(a_o ^ b_o);

   tri_t truth_a, truth_b;

   // reduce-AND / reduce-OR
   assign f_rand.zero = |a_z;
   assign f_rand.one  = &a_o;
   assign f_rand.unk  = ~(f_rand.zero | f_rand.one);
   assign f_ror.one   = |a_o;
   assign f_ror.zero  = &a_z;
   assign f_ror.unk   = ~(f_ror.zero | f_ror.one);

   // parity
   assign f_rxor.unk  = |a_x;
   assign f_rxor.one  = ~f_rxor.unk & (^a_o);
   assign f_rxor.zero = ~(f_rxor.unk | f_rxor.one);

   // logical operators on operand truth values
   assign truth_a.one  = |a_o;
   assign truth_a.zero = &a_z;
   assign truth_a.unk  = ~(truth_a.one | truth_a.zero);
   assign truth_b.one  = |b_o;
   assign truth_b.zero = &b_z;
   assign truth_b.unk  = ~(truth_b.one | truth_b.zero);
   assign f_land = t_and(truth_a, truth_b);
   assign f_lor  = t_or(truth_a, truth_b);

   // equality with pessimistic unknowns
   assign f_eq.zero = |diff_known;
   assign f_eq.unk  = ~f_eq.zero & (|any_unk);
   assign f_eq.one  = ~(f_eq.zero | f_eq.unk);
   assign f_ne      = t_not(f_eq);

   // exact state match
   assign f_ceq.one  = &same_state;
   assign f_ceq.zero = ~f_ceq.one;
   assign f_ceq.unk  = 1'b0;

   always_comb begin
      // R8/R9: an exact state match can never be a known inequality
      if (f_ceq.one)
         p_ceq_implies_eq_r8: assert (!f_eq.zero)
            else $error("case match but equality known false");
      // R7: logical AND true only if both reduce-OR style truths hold
      if (f_land.one)
         p_land_needs_ones_r7: assert ((|a_o) && (|b_o))
            else $error("logical AND true without known ones");
   end
endmodule

// File: rtl/xlogic_unit.sv
module xlogic_unit
   import xlu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]  a_data,
   input  logic [WIDTH-1:0]  a_mask,
   input  logic [WIDTH-1:0]  b_data,
   input  logic [WIDTH-1:0]  b_mask,
   input  logic [OPC_W-1:0]  opcode,
   output logic [WIDTH-1:0]  y_data,
   output logic [WIDTH-1:0]  y_mask
);
   localparam int UPPER = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("xlogic_unit: WIDTH must be at least 2");
   end

   tri_t [WIDTH-1:0] fa, fb;
   tri_t [WIDTH-1:0] v_not, v_and, v_or, v_xor, v_xnor;
   tri_t f_rand, f_ror, f_rxor, f_land, f_lor, f_eq, f_ne, f_ceq;
   tri_t [WIDTH-1:0] res;
   tri_t             bool_res;
   logic             is_bool;

   xlu_split #(.WIDTH(WIDTH)) split_a_i (.data(a_data), .mask(a_mask), .flags(fa));
   xlu_split #(.WIDTH(WIDTH)) split_b_i (.data(b_data), .mask(b_mask), .flags(fb));

   xlu_lanes #(.WIDTH(WIDTH)) lanes_i (
      .a(fa), .b(fb),
      .v_not(v_not), .v_and(v_and), .v_or(v_or), .v_xor(v_xor), .v_xnor(v_xnor)
   );

   xlu_fold #(.WIDTH(WIDTH)) fold_i (
      .a(fa), .b(fb),
      .f_rand(f_rand), .f_ror(f_ror), .f_rxor(f_rxor),
      .f_land(f_land), .f_lor(f_lor),
      .f_eq(f_eq), .f_ne(f_ne), .f_ceq(f_ceq)
   );

   always_comb begin
      is_bool  = 1'b1;
      bool_res = T_UNK;
      res      = {WIDTH{T_UNK}};
      case (opcode)
         OP_NOT:  begin is_bool = 1'b0; res = v_not;  end
         OP_AND:  begin is_bool = 1'b0; res = v_and;  end
         OP_OR:   begin is_bool = 1'b0; res = v_or;   end
         OP_XOR:  begin is_bool = 1'b0; res = v_xor;  end
         OP_XNOR: begin is_bool = 1'b0; res = v_xnor; end
         OP_RAND: bool_res = f_rand;
         OP_ROR:  bool_res = f_ror;
         OP_RXOR: bool_res = f_rxor;
         OP_LAND: bool_res = f_land;
         OP_LOR:  bool_res = f_lor;
         OP_EQ:   bool_res = f_eq;
         OP_NE:   bool_res = f_ne;
         OP_CEQ:  bool_res = f_ceq;
         default: is_bool = 1'b0;
      endcase
      if (is_bool) begin
         res    = {WIDTH{T_ZERO}};
         res[0] = bool_res;
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_out
      assign y_data[i] = res[i].one;
      assign y_mask[i] = res[i].unk;
   end

   always_comb begin
      p_out_clean_r1: assert ((y_data & y_mask) == '0)
         else $error("result data set under mask");
      if (opcode >= OP_RAND && opcode <= OP_CEQ)
         p_bool_upper_r10: assert (y_data[UPPER:1] == '0 && y_mask[UPPER:1] == '0)
            else $error("boolean result has nonzero upper bits");
      if (opcode == OP_CEQ)
         p_ceq_known_r9: assert (y_mask == '0)
            else $error("case equality reported unknown");
      if (opcode > OP_CEQ)
         p_unused_unknown_r11: assert (y_mask == '1 && y_data == '0)
            else $error("unused opcode not all unknown");
   end
endmodule

// File: tb/xlogic_unit_tb_top.sv
module xlogic_unit_tb_top;
   localparam int W = 8;
   localparam int CLK_PERIOD = 10;
   localparam int VECS_PER_OP = 400;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_data = '0, a_mask = '0, b_data = '0, b_mask = '0;
   logic [3:0]   opcode = '0;
   logic [W-1:0] y_data, y_mask;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlogic_unit #(.WIDTH(W)) dut_i (
      .a_data(a_data), .a_mask(a_mask), .b_data(b_data), .b_mask(b_mask),
      .opcode(opcode), .y_data(y_data), .y_mask(y_mask)
   );

   function automatic logic [31:0] nxt(logic [31:0] s);
      logic [31:0] t = s;
      t ^= t << 13; t ^= t >> 17; t ^= t << 5;
      return t;
   endfunction

   // three-state value: 0, 1, 2 = unknown
   function automatic int tv(logic d, logic m);
      return m ? 2 : (d ? 1 : 0);
   endfunction
   function automatic int and3(int a, int b);
      if (a == 0 || b == 0) return 0;
      if (a == 1 && b == 1) return 1;
      return 2;
   endfunction
   function automatic int or3(int a, int b);
      if (a == 1 || b == 1) return 1;
      if (a == 0 && b == 0) return 0;
      return 2;
   endfunction
   function automatic int xor3(int a, int b);
      if (a == 2 || b == 2) return 2;
      return a ^ b;
   endfunction
   function automatic int inv3(int a);
      return (a == 2) ? 2 : 1 - a;
   endfunction

   function automatic string req_of(int op);
      case (op)
         0: return "R4";  1, 2: return "R2";  3, 4: return "R3";
         5, 6: return "R5"; 7: return "R6"; 8, 9: return "R7";
         10, 11: return "R8"; 12: return "R9"; default: return "R11";
      endcase
   endfunction

   task automatic model(input int op, input logic [W-1:0] ad, am, bd, bm,
                        output logic [W-1:0] ed, em);
      int r [W];
      int s, ta, tb;
      bit any0, all1, anyx, diffk;
      int par;
      for (int i = 0; i < W; i++) r[i] = 0;
      s = 2;
      case (op)
         0: for (int i = 0; i < W; i++) r[i] = inv3(tv(ad[i], am[i]));
         1: for (int i = 0; i < W; i++) r[i] = and3(tv(ad[i], am[i]), tv(bd[i], bm[i]));
         2: for (int i = 0; i < W; i++) r[i] = or3(tv(ad[i], am[i]), tv(bd[i], bm[i]));
         3: for (int i = 0; i < W; i++) r[i] = xor3(tv(ad[i], am[i]), tv(bd[i], bm[i]));
         4: for (int i = 0; i < W; i++) r[i] = inv3(xor3(tv(ad[i], am[i]), tv(bd[i], bm[i])));
         default: ;
      endcase
      if (op >= 5 && op <= 12) begin
         case (op)
            5: begin
               s = 1;
               for (int i = 0; i < W; i++) s = and3(s, tv(ad[i], am[i]));
            end
            6: begin
               s = 0;
               for (int i = 0; i < W; i++) s = or3(s, tv(ad[i], am[i]));
            end
            7: begin
               s = 0;
               for (int i = 0; i < W; i++) s = xor3(s, tv(ad[i], am[i]));
            end
            8, 9: begin
               ta = 0; tb = 0;
               for (int i = 0; i < W; i++) begin
                  ta = or3(ta, tv(ad[i], am[i]));
                  tb = or3(tb, tv(bd[i], bm[i]));
               end
               s = (op == 8) ? and3(ta, tb) : or3(ta, tb);
            end
            10, 11: begin
               diffk = 0; anyx = 0;
               for (int i = 0; i < W; i++) begin
                  if (am[i] || bm[i]) anyx = 1;
                  else if (ad[i] != bd[i]) diffk = 1;
               end
               s = diffk ? 0 : (anyx ? 2 : 1);
               if (op == 11) s = inv3(s);
            end
            default: begin
               s = 1;
               for (int i = 0; i < W; i++)
                  if (tv(ad[i], am[i]) != tv(bd[i], bm[i])) s = 0;
            end
         endcase
         r[0] = s;
      end
      if (op > 12) for (int i = 0; i < W; i++) r[i] = 2;
      any0 = 0; all1 = 0; par = 0;
      for (int i = 0; i < W; i++) begin
         ed[i] = (r[i] == 1);
         em[i] = (r[i] == 2);
      end
   endtask

   task automatic check(input string req, input string what,
                        input logic [W-1:0] ed, em);
      checks++;
      if (y_data !== ed || y_mask !== em) begin
         failures++;
         $display("FAIL %s %s: got data=%b mask=%b expected data=%b mask=%b",
                  req, what, y_data, y_mask, ed, em);
      end
   endtask

   task automatic apply(input int op, input logic [W-1:0] ad, am, bd, bm);
      logic [W-1:0] ed, em, junk;
      model(op, ad, am, bd, bm, ed, em);
      @(negedge clk);
      opcode = op[3:0]; a_data = ad; a_mask = am; b_data = bd; b_mask = bm;
      #(CLK_PERIOD/4);
      check(req_of(op), "vector", ed, em);
      if (op >= 5 && op <= 12) check("R10", "upper bits", ed, em);
      // R1: scramble data under mask, result must not move
      seed = nxt(seed); junk = seed[W-1:0];
      @(negedge clk);
      a_data = ad ^ (junk & am);
      b_data = bd ^ (junk[0] ? ~junk & bm : junk & bm);
      #(CLK_PERIOD/4);
      check("R1", "masked data ignored", ed, em);
   endtask

   initial begin
      logic [W-1:0] ad, am, bd, bm;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk); #(CLK_PERIOD/4);
      // idle inputs: opcode 0 over A=0 known gives all known ones (R4)
      check("R4", "idle state", '1, '0);

      // directed corners
      apply(1, 8'h00, 8'hF0, 8'hFF, 8'h0F);          // R2 controlling zero vs unknown
      apply(2, 8'hFF, 8'h0F, 8'h00, 8'hF0);          // R2 controlling one
      apply(5, 8'hFF, 8'h00, 8'h00, 8'h00);          // R5 all ones
      apply(5, 8'hFE, 8'h01, 8'h00, 8'h00);          // R5 unknown only
      apply(5, 8'hFC, 8'h01, 8'h00, 8'h00);          // R5 known zero wins
      apply(6, 8'h00, 8'h80, 8'h00, 8'h00);          // R5 reduce-OR unknown
      apply(7, 8'h07, 8'h00, 8'h00, 8'h00);          // R6 odd parity
      apply(8, 8'h00, 8'h00, 8'h00, 8'hFF);          // R7 known false dominates
      apply(9, 8'h10, 8'h01, 8'h00, 8'hFF);          // R7 known true dominates
      apply(10, 8'hA5, 8'h00, 8'hA5, 8'h00);         // R8 equal
      apply(10, 8'hA5, 8'h01, 8'hA4, 8'h00);         // R8 unknown
      apply(10, 8'hA5, 8'h01, 8'h25, 8'h00);         // R8 known difference
      apply(12, 8'h00, 8'h0F, 8'hFF, 8'h0F);         // R9 unknowns match
      apply(12, 8'h00, 8'h01, 8'h00, 8'h00);         // R9 unknown vs zero
      for (int op = 13; op < 16; op++) apply(op, 8'h3C, 8'h00, 8'hC3, 8'h00); // R11

      // sweep every opcode
      for (int op = 0; op < 16; op++) begin
         for (int n = 0; n < VECS_PER_OP; n++) begin
            seed = nxt(seed); ad = seed[7:0];  bd = seed[15:8];
            am = seed[23:16] & seed[31:24];
            seed = nxt(seed);
            bm = (n % 3 == 0) ? 8'h00 : (seed[7:0] & seed[15:8] & seed[23:16]);
            if (n % 5 == 1) am = 8'h00;
            if (n % 4 == 2) begin bd = ad; bm = am; end
            if (n % 8 == 3) begin bd = ad; am = 8'h00; bm = 8'h00; end
            if (n % 16 == 5) begin ad = 8'hFF; am = 8'h00; end
            if (n % 16 == 7) begin ad = 8'h00; am = seed[27:20]; end
            apply(op, ad, am, bd, bm);
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL all watchdog: got cycles=%0d expected below %0d", cycles, WATCHDOG);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule